// File: doc/BRIEF.md
# Next Instruction Address Unit

This block produces the address of the next instruction for a small 32-bit RISC core and holds it in the program-counter register. Each clock it picks one of five candidates: the sequential address four bytes on, a PC-relative branch destination, an absolute jump destination built from the top PC bits and a 26-bit target field, an address read from a register operand, or a fixed entry point for system calls. The opcode decoder outside the block supplies a source select and a branch kind. The register file supplies the two operands. The block itself decides whether a conditional branch is taken.

Addresses are handled as 30-bit word numbers, so the register always holds an address with its two lowest bits at zero. The branch offset is a sign-extended immediate counted in words. A synchronous reset returns the register to address zero.

Selections, with the names used in the RTL: the source select is SRC_SEQ (00), SRC_JUMP (01), SRC_REG (10) or SRC_SYS (11). The branch kind is BR_NONE (00), BR_EQ (01), BR_NE (10) or BR_NEG (11). The branch kind has an effect only under SRC_SEQ.

Top module: `pcn_core`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_q` becomes 0 at that edge.
- R2: With `src_sel`=00 and `br_kind`=00, `pc_q` advances by 4 at each edge.
- R3: With `src_sel`=00 and `br_kind`=01 (equal), `pc_q` becomes `pc_q`+4+4·`imm_ext` if `rs_val`==`rt_val`. Otherwise it becomes `pc_q`+4.
- R4: With `src_sel`=00 and `br_kind`=10 (not equal), `pc_q` becomes `pc_q`+4+4·`imm_ext` if `rs_val`!=`rt_val`. Otherwise it becomes `pc_q`+4.
- R5: With `src_sel`=00 and `br_kind`=11 (negative), the branch is taken exactly when `rs_val[31]` is 1, whatever `rt_val` holds. A taken branch goes to `pc_q`+4+4·`imm_ext`. An untaken one goes to `pc_q`+4.
- R6: With `src_sel`=01, `pc_q` becomes {`pc_q[31:28]`, `jump_tgt`, 2'b00}.
- R7: With `src_sel`=10, `pc_q` becomes {`rs_val[31:2]`, 2'b00}.
- R8: With `src_sel`=11, `pc_q` becomes the parameter `SYS_VEC` with its two low bits cleared.
- R9: When `src_sel` is not 00, `br_kind` and the operand comparison have no effect on `pc_q`.
- R10: `pc_q[1:0]` is 00 after every edge, including when `rs_val` or `SYS_VEC` has nonzero low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Next-address source: 00 sequential/branch, 01 jump, 10 register, 11 system call |
| br_kind | input | 2 | Branch kind: 00 none, 01 equal, 10 not equal, 11 negative |
| rs_val | input | 32 | First register operand; also the register jump address |
| rt_val | input | 32 | Second register operand for the comparison |
| imm_ext | input | 32 | Sign-extended immediate, branch offset in words |
| jump_tgt | input | 26 | Absolute jump target in words |
| pc_q | output | 32 | Program-counter register |

## Verification
Each result is due one clock after its inputs are set up: the selection is combinational and is loaded into `pc_q` at the next rising edge. The bench therefore changes the inputs on a falling edge, waits through one rising edge, and compares `pc_q` at the following falling edge with its own model of the previous address. The model is then updated to the expected value, so a wrong step is reported once and does not hide later steps. The embedded properties check the same relation edge by edge, using `$past` of the inputs and of `pc_q`.

// File: rtl/pcn_pkg.sv
package pcn_pkg;

    typedef enum logic [1:0] {
        SRC_SEQ  = 2'b00,
        SRC_JUMP = 2'b01,
        SRC_REG  = 2'b10,
        SRC_SYS  = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        BR_NONE = 2'b00,
        BR_EQ   = 2'b01,
        BR_NE   = 2'b10,
        BR_NEG  = 2'b11
    } br_e;

endpackage

// File: rtl/pcn_branch_eval.sv
module pcn_branch_eval
    import pcn_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  br_e               kind,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              taken
);

    logic same;
    assign same = (opa == opb);

    always_comb begin
        unique case (kind)
            BR_NONE: taken = 1'b0;
            BR_EQ:   taken = same;
            BR_NE:   taken = !same;
            BR_NEG:  taken = opa[DATA_W-1];
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcn_target_gen.sv
module pcn_target_gen
    import pcn_pkg::*;
#(
    parameter int WORD_W = 30,
    parameter int JT_W   = 26,
    parameter logic [WORD_W-1:0] SYS_WORD = '0
) (
    input  src_e              src,
    input  logic              taken,
    input  logic [WORD_W-1:0] pc_word,
    input  logic [WORD_W-1:0] rs_word,
    input  logic [WORD_W-1:0] off_word,
    input  logic [JT_W-1:0]   jt,
    output logic [WORD_W-1:0] next_word
);

    localparam int HI_W = WORD_W - JT_W;

    logic [WORD_W-1:0] step_word;
    logic [WORD_W-1:0] add_word;

    // One adder serves both the sequential step and the branch target.
    assign add_word  = taken ? off_word : '0;
    assign step_word = pc_word + add_word + {{(WORD_W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (src)
            SRC_SEQ:  next_word = step_word;
            SRC_JUMP: next_word = {pc_word[WORD_W-1 -: HI_W], jt};
            SRC_REG:  next_word = rs_word;
            SRC_SYS:  next_word = SYS_WORD;
            default:  next_word = step_word;
        endcase
    end

endmodule

// File: rtl/pcn_core.sv
module pcn_core
    import pcn_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          JT_W    = 26,
    parameter logic [31:0] SYS_VEC = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        src_sel,
    input  logic [1:0]        br_kind,
    input  logic [ADDR_W-1:0] rs_val,
    input  logic [ADDR_W-1:0] rt_val,
    input  logic [ADDR_W-1:0] imm_ext,
    input  logic [JT_W-1:0]   jump_tgt,
    output logic [ADDR_W-1:0] pc_q
);

    localparam int WORD_W = ADDR_W - 2;
    localparam int HI_W   = WORD_W - JT_W;
    localparam logic [WORD_W-1:0] SYS_WORD = SYS_VEC[ADDR_W-1:2];

    src_e              src;
    br_e               kind;
    logic              taken;
    logic [WORD_W-1:0] next_word;
    logic              unused_bits;

    assign src         = src_e'(src_sel);
    assign kind        = br_e'(br_kind);
    assign unused_bits = ^{imm_ext[ADDR_W-1:WORD_W], rs_val[1:0]};

    pcn_branch_eval #(
        .DATA_W (ADDR_W)
    ) u_eval (
        .kind  (kind),
        .opa   (rs_val),
        .opb   (rt_val),
        .taken (taken)
    );

    pcn_target_gen #(
        .WORD_W   (WORD_W),
        .JT_W     (JT_W),
        .SYS_WORD (SYS_WORD)
    ) u_tgt (
        .src       (src),
        .taken     (taken),
        .pc_word   (pc_q[ADDR_W-1:2]),
        .rs_word   (rs_val[ADDR_W-1:2]),
        .off_word  (imm_ext[WORD_W-1:0]),
        .jt        (jump_tgt),
        .next_word (next_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= {next_word, 2'b00};
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> pc_q == '0); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b00 && br_kind == 2'b00)
        |=> pc_q == $past(pc_q) + ADDR_W'(4)); // R2

    AST_EQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b00 && br_kind == 2'b01 && rs_val != rt_val)
        |=> pc_q == $past(pc_q) + ADDR_W'(4)); // R3

    AST_NE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b00 && br_kind == 2'b10 && rs_val != rt_val)
        |=> pc_q == $past(pc_q) + ADDR_W'(4) + {$past(imm_ext[WORD_W-1:0]), 2'b00}); // R4

    AST_NEG_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b00 && br_kind == 2'b11 && rs_val[ADDR_W-1])
        |=> pc_q == $past(pc_q) + ADDR_W'(4) + {$past(imm_ext[WORD_W-1:0]), 2'b00}); // R5

    AST_JUMP_ABS: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b01)
        |=> pc_q == {$past(pc_q[ADDR_W-1 -: HI_W]), $past(jump_tgt), 2'b00}); // R6

    AST_JUMP_REG: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b10)
        |=> pc_q[ADDR_W-1:2] == $past(rs_val[ADDR_W-1:2])); // R7

    AST_SYS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b11)
        |=> pc_q[ADDR_W-1:2] == SYS_VEC[ADDR_W-1:2]); // R8

    AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_q[1:0] == 2'b00); // R10

endmodule

// File: tb/sim_pcn_core.sv
module sim_pcn_core;

    localparam logic [31:0] VEC = 32'h8000_0183;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  src_sel;
    logic [1:0]  br_kind;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [31:0] imm_ext;
    logic [25:0] jump_tgt;
    logic [31:0] pc_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] exp_pc;

    always #4 clk = ~clk;

    pcn_core #(.SYS_VEC(VEC)) u0 (
        .clk      (clk),
        .rst      (rst),
        .src_sel  (src_sel),
        .br_kind  (br_kind),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .imm_ext  (imm_ext),
        .jump_tgt (jump_tgt),
        .pc_q     (pc_q)
    );

    function automatic logic [31:0] model_next(logic [31:0] pc, logic [1:0] s,
            logic [1:0] b, logic [31:0] a, logic [31:0] c, logic [31:0] im,
            logic [25:0] jt);
        logic tk;
        case (b)
            2'b01:   tk = (a == c);
            2'b10:   tk = (a != c);
            2'b11:   tk = a[31];
            default: tk = 1'b0;
        endcase
        case (s)
            2'b00:   return tk ? pc + 32'd4 + (im << 2) : pc + 32'd4;
            2'b01:   return {pc[31:28], jt, 2'b00};
            2'b10:   return {a[31:2], 2'b00};
            default: return {VEC[31:2], 2'b00};
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] s, logic [1:0] b);
        if (s == 2'b01) return "R6";
        if (s == 2'b10) return "R7";
        if (s == 2'b11) return "R8";
        if (b == 2'b01) return "R3";
        if (b == 2'b10) return "R4";
        if (b == 2'b11) return "R5";
        return "R2";
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pc_q actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic [1:0] s, logic [1:0] b, logic [31:0] a,
            logic [31:0] c, logic [31:0] im, logic [25:0] jt);
        logic [31:0] e;
        src_sel = s; br_kind = b; rs_val = a; rt_val = c; imm_ext = im; jump_tgt = jt;
        e = model_next(exp_pc, s, b, a, c, im, jt);
        @(posedge clk);
        @(negedge clk);
        check(tag, pc_q, e);
        if (pc_q[1:0] !== 2'b00) check("R10", {30'd0, pc_q[1:0]}, 32'd0);
        exp_pc = e;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", pc_q, 32'd0);
        rst = 1'b0;
        exp_pc = 32'd0;
    endtask

    initial begin
        rst = 1'b1; src_sel = 2'b00; br_kind = 2'b00;
        rs_val = '0; rt_val = '0; imm_ext = '0; jump_tgt = '0;
        exp_pc = '0;
        @(negedge clk);
        do_reset();
        step("R2", 2'b00, 2'b00, 32'h5, 32'h5, 32'h10, 26'h0);
        step("R2", 2'b00, 2'b00, 32'h0, 32'h1, 32'h0, 26'h0);
        step("R3", 2'b00, 2'b01, 32'h1234, 32'h1234, 32'h40, 26'h0);
        step("R3", 2'b00, 2'b01, 32'h1234, 32'h1235, 32'h40, 26'h0);
        step("R3", 2'b00, 2'b01, 32'h7, 32'h7, 32'hFFFF_FFF0, 26'h0);
        step("R4", 2'b00, 2'b10, 32'h1, 32'h2, 32'h8, 26'h0);
        step("R4", 2'b00, 2'b10, 32'h9, 32'h9, 32'h8, 26'h0);
        step("R5", 2'b00, 2'b11, 32'h8000_0000, 32'h8000_0000, 32'h3, 26'h0);
        step("R5", 2'b00, 2'b11, 32'h7FFF_FFFF, 32'h1, 32'h3, 26'h0);
        step("R6", 2'b01, 2'b00, 32'h0, 32'h0, 32'h0, 26'h3FF_FFFF);
        step("R7", 2'b10, 2'b00, 32'hF000_0007, 32'h0, 32'h0, 26'h0);
        step("R6", 2'b01, 2'b00, 32'h0, 32'h0, 32'h0, 26'h12_3456);
        step("R8", 2'b11, 2'b00, 32'h0, 32'h0, 32'h0, 26'h0);
        step("R9", 2'b01, 2'b01, 32'h44, 32'h44, 32'h100, 26'h0AB);
        step("R9", 2'b10, 2'b11, 32'h8000_0ABF, 32'h0, 32'h100, 26'h0);
        step("R9", 2'b11, 2'b10, 32'h1, 32'h2, 32'h100, 26'h0);
        step("R10", 2'b10, 2'b00, 32'h0000_0003, 32'h0, 32'h0, 26'h0);
        step("R2", 2'b00, 2'b00, 32'h0, 32'h0, 32'h0, 26'h0);
        do_reset();
        void'($urandom(32'd20251));
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  s;
            logic [1:0]  b;
            logic [31:0] a;
            logic [31:0] c;
            logic [31:0] im;
            s  = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 9) < 6) s = 2'b00;
            b  = 2'($urandom_range(0, 3));
            a  = $urandom();
            c  = ($urandom_range(0, 1) == 1) ? a : $urandom();
            im = {{16{1'b0}}, 16'($urandom())};
            im = {{16{im[15]}}, im[15:0]};
            step(tag_of(s, b), s, b, a, c, im, 26'($urandom()));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule